// File: doc/BRIEF.md
# In-Place Byte Sorter for a Single-Port RAM

This block reorders the bytes held in an external single-port RAM. The storage is not part of the block. It steps through the RAM with a neighbour-exchange (bubble) sort. Each cycle it issues exactly one access on the port, either a read or a write. The sorted bytes are written back into the same locations they were read from.

A two-bit ordering selector picks one of four orderings:

| Code | Ordering |
|------|----------|
| 0 | signed, largest first |
| 1 | signed, smallest first |
| 2 | unsigned, largest first |
| 3 | unsigned, smallest first |

A one-cycle `adv_i` pulse moves the selector to the next code, and code 3 wraps to 0. A one-cycle `start_i` pulse launches a sort with the code shown at that moment.

The controller drives the RAM port as plain control signals. The RAM is expected to return read data one cycle after the address. The block has no streaming data path, so it has no valid/ready handshake and applies no back-pressure. `busy_o` and `done_o` report progress.

Top module: `ram_sorter`

## Requirements
- R1: After reset, `mode_o` is 0, and `busy_o`, `done_o` and `ram_we_o` are all low.
- R2: While `busy_o` is low, each `adv_i` pulse steps `mode_o` by one, in the order 0,1,2,3, and 3 wraps to 0.
- R3: `adv_i` pulses while `busy_o` is high leave `mode_o` unchanged and do not alter the ordering of the running sort.
- R4: A `start_i` pulse while both `busy_o` and `done_o` are low raises `busy_o` on the next cycle. A `start_i` pulse while `busy_o` is high has no effect: no second sort follows.
- R5: On completion, every adjacent pair in the RAM obeys the chosen ordering. Codes 0 and 2 leave each byte not smaller than the byte at the next address. Codes 1 and 3 leave each byte not larger than the byte at the next address.
- R6: Codes 0 and 1 compare bytes as two's complement, so 0x80 is the smallest value and 0x7F the largest. Codes 2 and 3 rank 0x00 smallest and 0xFF largest.
- R7: The RAM ends with the same multiset of bytes it started with. Writes occur only while `busy_o` is high, and they come as back-to-back pairs.
- R8: If a full pass makes no exchange, the sort ends after that pass. For data already in the chosen order, `busy_o` stays high for exactly 3·(N−1) cycles, where N is the number of entries. Otherwise the sort ends after at most N−1 passes.
- R9: `done_o` pulses high for a single cycle right after `busy_o` falls, and `busy_o` is low during that cycle.
- R10: When `start_i` and `adv_i` arrive together while idle, the sort uses the code shown before the step, and `mode_o` still advances.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch a sort (one-cycle pulse) |
| adv_i | input | 1 | Step the ordering selector (one-cycle pulse) |
| mode_o | output | 2 | Currently selected ordering code |
| ram_addr_o | output | AW | RAM address |
| ram_we_o | output | 1 | RAM write enable |
| ram_wdata_o | output | DW | RAM write data |
| ram_rdata_i | input | DW | RAM read data, valid one cycle after the address |
| busy_o | output | 1 | Sort in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Two events can land in the same idle cycle: a launch and a selector step. The bench raises `start_i` and `adv_i` on the same edge. It then checks that `mode_o` has moved to the next code, and that the RAM contents are ordered by the code that was shown before the step. A related collision is a step or a second launch arriving mid-sort. Its effect is judged by watching `mode_o` stay fixed, checking the final RAM ordering, and confirming that `busy_o` does not rise again after `done_o`.

// File: rtl/sorter_pkg.sv
package sorter_pkg;
  // bit1: 0 = signed, 1 = unsigned; bit0: 0 = largest first, 1 = smallest first
  typedef enum logic [1:0] {
    ORD_S_DESC = 2'd0,
    ORD_S_ASC  = 2'd1,
    ORD_U_DESC = 2'd2,
    ORD_U_ASC  = 2'd3
  } order_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_LO,
    ST_RD_HI,
    ST_CMP,
    ST_WR_LO,
    ST_WR_HI,
    ST_FIN
  } sort_state_e;
endpackage

// File: rtl/order_select.sv
module order_select
  import sorter_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   adv_i,
  input  logic   hold_i,
  output order_e order_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      order_o <= ORD_S_DESC;
    else if (adv_i && !hold_i)
      order_o <= order_e'(order_o + 2'd1);
  end
endmodule

// File: rtl/order_compare.sv
module order_compare
  import sorter_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] lo_i,
  input  logic [DW-1:0] hi_i,
  input  order_e        order_i,
  output logic          exch_o
);
  logic use_unsigned, want_asc, lo_big, hi_big;

  always_comb begin
    use_unsigned = order_i[1];
    want_asc     = order_i[0];
    if (use_unsigned) begin
      lo_big = lo_i > hi_i;
      hi_big = hi_i > lo_i;
    end else begin
      lo_big = $signed(lo_i) > $signed(hi_i);
      hi_big = $signed(hi_i) > $signed(lo_i);
    end
    exch_o = want_asc ? lo_big : hi_big;
  end
endmodule

// File: rtl/sort_ctrl.sv
module sort_ctrl
  import sorter_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  order_e        order_i,
  input  logic          exch_i,
  output order_e        run_order_o,
  output logic [DW-1:0] cmp_lo_o,
  output logic [DW-1:0] cmp_hi_o,
  output logic [AW-1:0] ram_addr_o,
  output logic          ram_we_o,
  output logic [DW-1:0] ram_wdata_o,
  input  logic [DW-1:0] ram_rdata_i,
  output logic          busy_o,
  output logic          done_o
);
  localparam int N = 1 << AW;
  localparam logic [AW-1:0] LAST = AW'(N - 2);

  sort_state_e   state;
  logic [AW-1:0] idx, pass;
  logic          any_exch;
  logic [DW-1:0] lo_q, hi_q;
  logic          pass_end, finish;

  assign pass_end = (idx == LAST);
  assign finish   = pass_end && (!any_exch || pass == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      idx         <= '0;
      pass        <= '0;
      any_exch    <= 1'b0;
      lo_q        <= '0;
      hi_q        <= '0;
      run_order_o <= ORD_S_DESC;
    end else begin
      unique case (state)
        ST_IDLE: if (start_i) begin
          run_order_o <= order_i;
          idx         <= '0;
          pass        <= '0;
          any_exch    <= 1'b0;
          state       <= ST_RD_LO;
        end
        ST_RD_LO: state <= ST_RD_HI;
        ST_RD_HI: begin
          lo_q  <= ram_rdata_i;
          state <= ST_CMP;
        end
        ST_CMP: begin
          hi_q <= ram_rdata_i;
          if (exch_i) begin
            any_exch <= 1'b1;
            state    <= ST_WR_LO;
          end else if (finish) begin
            state <= ST_FIN;
          end else if (pass_end) begin
            pass     <= pass + 1'b1;
            idx      <= '0;
            any_exch <= 1'b0;
            state    <= ST_RD_LO;
          end else begin
            idx   <= idx + 1'b1;
            state <= ST_RD_LO;
          end
        end
        ST_WR_LO: state <= ST_WR_HI;
        ST_WR_HI: begin
          if (finish) begin
            state <= ST_FIN;
          end else if (pass_end) begin
            pass     <= pass + 1'b1;
            idx      <= '0;
            any_exch <= 1'b0;
            state    <= ST_RD_LO;
          end else begin
            idx   <= idx + 1'b1;
            state <= ST_RD_LO;
          end
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cmp_lo_o    = lo_q;
  assign cmp_hi_o    = ram_rdata_i;
  assign ram_addr_o  = (state == ST_RD_HI || state == ST_WR_HI) ? idx + 1'b1 : idx;
  assign ram_we_o    = (state == ST_WR_LO) || (state == ST_WR_HI);
  assign ram_wdata_o = (state == ST_WR_LO) ? hi_q : lo_q;
  assign busy_o      = (state != ST_IDLE) && (state != ST_FIN);
  assign done_o      = (state == ST_FIN);
endmodule

// File: rtl/ram_sorter.sv
module ram_sorter
  import sorter_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          adv_i,
  output logic [1:0]    mode_o,
  output logic [AW-1:0] ram_addr_o,
  output logic          ram_we_o,
  output logic [DW-1:0] ram_wdata_o,
  input  logic [DW-1:0] ram_rdata_i,
  output logic          busy_o,
  output logic          done_o
);
  order_e        sel_order, run_order;
  logic [DW-1:0] cmp_lo, cmp_hi;
  logic          exch;

  order_select u_sel (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv_i   (adv_i),
    .hold_i  (busy_o),
    .order_o (sel_order)
  );

  order_compare #(.DW(DW)) u_cmp (
    .lo_i    (cmp_lo),
    .hi_i    (cmp_hi),
    .order_i (run_order),
    .exch_o  (exch)
  );

  sort_ctrl #(.DW(DW), .AW(AW)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .order_i     (sel_order),
    .exch_i      (exch),
    .run_order_o (run_order),
    .cmp_lo_o    (cmp_lo),
    .cmp_hi_o    (cmp_hi),
    .ram_addr_o  (ram_addr_o),
    .ram_we_o    (ram_we_o),
    .ram_wdata_o (ram_wdata_o),
    .ram_rdata_i (ram_rdata_i),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

  assign mode_o = sel_order;
endmodule

// File: rtl/ram_sorter_chk.sv
module ram_sorter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic [1:0] mode_o,
  input logic       ram_we_o,
  input logic       busy_o,
  input logic       done_o
);
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  a_r9_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);
  a_r7_write_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we_o |-> busy_o);
  a_r7_write_pair: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_we_o) |=> ram_we_o);
  a_r7_pair_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we_o && $past(ram_we_o)) |=> !ram_we_o);
  a_r3_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(mode_o));
  a_r4_start_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && !done_o) |=> busy_o);
endmodule

bind ram_sorter ram_sorter_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_i  (start_i),
  .mode_o   (mode_o),
  .ram_we_o (ram_we_o),
  .busy_o   (busy_o),
  .done_o   (done_o)
);

// File: tb/tb_ram_sorter.sv
module tb_ram_sorter;
  localparam int DW = 8;
  localparam int AW = 5;
  localparam int N  = 1 << AW;

  logic clk = 0, rst_n = 0, start_i = 0, adv_i = 0;
  logic [1:0]    mode_o;
  logic [AW-1:0] ram_addr_o;
  logic          ram_we_o, busy_o, done_o;
  logic [DW-1:0] ram_wdata_o, ram_rdata_i;
  logic [DW-1:0] mem [N];

  int checks = 0, errors = 0, cyc = 0;

  always #5 clk = ~clk;

  ram_sorter #(.DW(DW), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .adv_i(adv_i), .mode_o(mode_o),
    .ram_addr_o(ram_addr_o), .ram_we_o(ram_we_o), .ram_wdata_o(ram_wdata_o),
    .ram_rdata_i(ram_rdata_i), .busy_o(busy_o), .done_o(done_o)
  );

  always @(posedge clk) begin
    if (ram_we_o) mem[ram_addr_o] <= ram_wdata_o;
    ram_rdata_i <= mem[ram_addr_o];
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // [9:8] ordering code, [11:10] fill kind, [7:0] seed
  localparam logic [11:0] VEC [8] = '{
    12'h0_5A, 12'h1_C3, 12'h2_17, 12'h3_99,
    12'hC_00, 12'hD_00, 12'h6_00, 12'hB_21
  };

  int hist_in [256];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit in_order(input logic [7:0] x, input logic [7:0] y, input logic [1:0] m);
    int sx, sy;
    sx = m[1] ? int'(x) : int'($signed(x));
    sy = m[1] ? int'(y) : int'($signed(y));
    return m[0] ? (sx <= sy) : (sx >= sy);
  endfunction

  task automatic fill(input logic [1:0] kind, input logic [7:0] seed);
    logic [7:0] r = seed | 8'h01;
    for (int i = 0; i < 256; i++) hist_in[i] = 0;
    for (int i = 0; i < N; i++) begin
      r = {r[6:0], r[7] ^ r[5] ^ r[4] ^ r[3]};
      case (kind)
        2'd0: mem[i] = r;
        2'd1: mem[i] = 8'(i * 7);
        2'd2: mem[i] = 8'(8'hF0 - i * 5);
        default: mem[i] = (i % 4 == 0) ? 8'h80 : (i % 4 == 1) ? 8'h7F :
                          (i % 4 == 2) ? 8'h00 : 8'hFF;
      endcase
      hist_in[mem[i]]++;
    end
  endtask

  task automatic set_mode(input logic [1:0] m);
    int guard = 0;
    while (mode_o != m && guard < 8) begin
      adv_i = 1; @(negedge clk); adv_i = 0; @(negedge clk);
      guard++;
    end
  endtask

  task automatic launch_and_wait(input bit with_adv, output int busy_cyc);
    busy_cyc = 0;
    start_i = 1; adv_i = with_adv;
    @(negedge clk);
    start_i = 0; adv_i = 0;
    while (!done_o) begin
      if (busy_o) busy_cyc++;
      @(negedge clk);
    end
  endtask

  task automatic check_result(input logic [1:0] m, input string req);
    int bad = 0, hdiff = 0;
    int h [256];
    for (int i = 0; i < 256; i++) h[i] = 0;
    for (int i = 0; i < N; i++) h[mem[i]]++;
    for (int i = 0; i < 256; i++) if (h[i] != hist_in[i]) hdiff++;
    for (int i = 0; i < N - 1; i++) if (!in_order(mem[i], mem[i+1], m)) bad++;
    check(bad == 0, req, bad, 0);
    check(hdiff == 0, "R7 permutation", hdiff, 0);
  endtask

  initial begin
    int bc;
    @(negedge clk); @(negedge clk);
    // R1 reset state
    check(mode_o == 2'd0 && !busy_o && !done_o && !ram_we_o, "R1 reset",
          {mode_o, busy_o, done_o, ram_we_o}, 0);
    rst_n = 1;
    @(negedge clk);

    // R2 stepping and wrap
    for (int k = 1; k <= 4; k++) begin
      adv_i = 1; @(negedge clk); adv_i = 0;
      check(mode_o == 2'(k), "R2 advance", mode_o, k % 4);
    end

    // table of vectors: R5 ordering under each code and fill
    for (int v = 0; v < 8; v++) begin
      fill(VEC[v][11:10], VEC[v][7:0]);
      set_mode(VEC[v][9:8]);
      launch_and_wait(1'b0, bc);
      check(!busy_o, "R9 done with busy low", busy_o, 0);
      @(negedge clk);
      check(!done_o, "R9 done single cycle", done_o, 0);
      check_result(VEC[v][9:8], "R5 order");
    end

    // R6 signed extremes
    fill(2'd3, 8'h00); set_mode(2'd1); launch_and_wait(1'b0, bc); @(negedge clk);
    check(mem[0] == 8'h80 && mem[N-1] == 8'h7F, "R6 signed asc ends", mem[0], 8'h80);
    fill(2'd3, 8'h00); set_mode(2'd3); launch_and_wait(1'b0, bc); @(negedge clk);
    check(mem[0] == 8'h00 && mem[N-1] == 8'hFF, "R6 unsigned asc ends", mem[0], 8'h00);

    // R8 early exit on sorted data
    fill(2'd1, 8'h00); set_mode(2'd3); launch_and_wait(1'b0, bc); @(negedge clk);
    check(bc == 3 * (N - 1), "R8 early exit busy cycles", bc, 3 * (N - 1));

    // R3 advance during sort, R4 start during sort
    fill(2'd2, 8'h00); set_mode(2'd3);
    start_i = 1; @(negedge clk); start_i = 0;
    check(busy_o, "R4 start raises busy", busy_o, 1);
    repeat (20) @(negedge clk);
    adv_i = 1; start_i = 1; @(negedge clk); adv_i = 0; start_i = 0;
    repeat (3) @(negedge clk);
    check(mode_o == 2'd3, "R3 mode frozen while busy", mode_o, 3);
    while (!done_o) @(negedge clk);
    @(negedge clk);
    begin
      int rises = 0;
      for (int k = 0; k < 5; k++) begin if (busy_o) rises++; @(negedge clk); end
      check(rises == 0, "R4 no second sort", rises, 0);
    end
    check_result(2'd3, "R3 order kept");

    // R10 start and advance together
    fill(2'd0, 8'h3C); set_mode(2'd2);
    launch_and_wait(1'b1, bc); @(negedge clk);
    check(mode_o == 2'd3, "R10 mode advanced", mode_o, 3);
    check_result(2'd2, "R10 pre-step order used");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule